// File: doc/BRIEF.md
# Wiper Position Store Controller

This block keeps a nonvolatile copy of a 4-bit tap position for a push-button potentiometer. It chooses when the live position is copied into the nonvolatile cell, and it hands the saved value back to the position counter once after every reset. The nonvolatile cell is modelled as a register that survives reset and has a fixed write window. While that window is open the block reports itself busy.

The level of an active-low store-enable pin is captured while reset is held, and that level selects the store mode for the rest of the session. A low pin selects automatic storing: the position is saved once the stepping inputs have been quiet for two seconds, unless it already matches what is saved. A high pin selects manual storing: a debounced press and release of the same pin saves the position. While the pin is held down, stepping is locked out. All timing is counted in 1 ms ticks supplied from outside.

Top module: `wiper_store_ctrl`

## Requirements
- R1: The mode is taken from the store-enable pin while reset is low: low selects automatic, high selects manual. Pin changes after reset never change the mode, and in automatic mode the pin causes neither a store nor an inhibit.
- R2: In the first cycle after reset is released, `recall_load` is high for exactly one cycle and `recall_pos` carries the saved position.
- R3: If nothing has ever been stored, the cell holds middle scale, binary 1000 (decimal 8).
- R4: In automatic mode a write starts once IDLE_MS ticks have passed since the last activity pulse. `nv_busy` rises exactly IDLE_MS cycles after the pulse when a tick arrives every cycle. Every new pulse restarts the count.
- R5: In automatic mode no write starts when the position equals the saved value. After an expiry, no further write starts until a new activity pulse arrives.
- R6: In manual mode a write starts after the pin has been debounced low (DEB_MS ticks) and then debounced high again. `nv_busy` rises 18 cycles after the release is driven, with default parameters and a tick every cycle. A low shorter than DEB_MS ticks starts nothing.
- R7: In manual mode `step_inhibit` is high from two cycles after the pin goes low until the debounced pin is high again.
- R8: A write keeps `nv_busy` high for WR_MS ticks (20 cycles by default) and only then updates the saved value. `step_inhibit` is high throughout the write.
- R9: Activity pulses and pin edges that arrive during a write are ignored. They neither arm a later store nor start one.
- R10: In manual mode activity pulses never start a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is sampled while it is low |
| store_en_n | input | 1 | Raw active-low store-enable / store push-button pin |
| step_act | input | 1 | One-cycle pulse for each activity on the stepping inputs |
| cur_pos | input | 4 | Live wiper position |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| recall_pos | output | 4 | Saved position from the nonvolatile cell |
| recall_load | output | 1 | One-cycle strobe after reset telling the counter to load `recall_pos` |
| nv_busy | output | 1 | High while a nonvolatile write is in progress |
| step_inhibit | output | 1 | High when the stepping inputs must be ignored |

## Verification
A corrupted saved value stays hidden until the next reset. It then shows up as a wrong `recall_pos` alongside the strobe, so the bench resets after each store and compares the recalled value against a scoreboard. A wrong idle or debounce counter shows up as `nv_busy` rising one or more cycles early or late, so the rise is sampled in the exact cycle it is due. A stale arm flag or a wrongly latched mode shows up as an unwanted write during windows that last longer than a full idle period.

// File: rtl/wsc_pkg.sv
// Shared types for the wiper position store controller.
package wsc_pkg;
    // Store mode chosen at reset from the store-enable pin level.
    typedef enum logic {
        MODE_MANUAL = 1'b0,
        MODE_AUTO   = 1'b1
    } store_mode_e;
endpackage

// File: rtl/wsc_pin_filter.sv
// Synchronises and debounces the store-enable pin.
// Assumes: tick is a one-cycle pulse; the filtered level follows the pin
// only after the pin has disagreed with it for DEB_TICKS consecutive ticks.
module wsc_pin_filter #(
    parameter int DEB_TICKS = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_raw,
    output logic pin_sync,
    output logic lvl,
    output logic rise
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser, deliberately left free-running through reset.
    always_ff @(posedge clk) begin
        s1 <= pin_raw;
        s2 <= s1;
    end

    assign pin_sync = s2;

    // Debounce counter; the filtered level flips after a stable disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= s2;
            cnt  <= '0;
            rise <= 1'b0;
        end else begin
            rise <= 1'b0;
            if (s2 != lvl) begin
                if (tick) begin
                    if (cnt == CW'(DEB_TICKS - 1)) begin
                        lvl  <= s2;
                        cnt  <= '0;
                        rise <= s2;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    AST_LVL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lvl)); // R6

endmodule

// File: rtl/wsc_idle_timer.sv
// Inactivity timer for automatic storing.
// Assumes: act is a one-cycle pulse; while hold is high, activity is dropped.
// The timer arms on activity and expires once, IDLE_TICKS ticks later.
module wsc_idle_timer #(
    parameter int IDLE_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic act,
    input  logic hold,
    output logic expire
);
    localparam int IW = $clog2(IDLE_TICKS + 1);

    logic          armed;
    logic [IW-1:0] cnt;

    assign expire = en && armed && tick && (cnt == IW'(IDLE_TICKS - 1));

    // Arm and restart on activity, disarm on expiry, count ticks while armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (act && !hold && en) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (expire) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DISARM_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !act) |=> !armed); // R5
    AST_NO_ARM_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !$rose(armed)); // R9

endmodule

// File: rtl/wsc_nv_cell.sv
// Nonvolatile position cell with a timed write window.
// Assumes: the stored value is not cleared by reset (it models nonvolatile
// storage) and starts at INIT. A start request is ignored while busy.
// The new value is committed at the end of the WR_TICKS window.
module wsc_nv_cell #(
    parameter int          W        = 4,
    parameter int          WR_TICKS = 20,
    parameter logic [W-1:0] INIT    = 4'b1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic [W-1:0] q
);
    localparam int WW = $clog2(WR_TICKS + 1);

    logic [WW-1:0] wcnt;
    logic [W-1:0]  wdata;
    logic [W-1:0]  mem = INIT;
    logic          commit;

    assign commit = busy && tick && (wcnt == WW'(WR_TICKS - 1));
    assign q      = mem;

    // Write window sequencing: capture data on start, count ticks, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            wcnt  <= '0;
            wdata <= '0;
        end else if (busy) begin
            if (commit) begin
                busy <= 1'b0;
                wcnt <= '0;
            end else if (tick) begin
                wcnt <= wcnt + 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            wcnt  <= '0;
            wdata <= din;
        end
    end

    // Storage element, updated only when a write window completes.
    always_ff @(posedge clk) begin
        if (rst_n && commit) begin
            mem <= wdata;
        end
    end

    AST_CELL_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(q)); // R8

endmodule

// File: rtl/wiper_store_ctrl.sv
// Wiper position store controller (top).
// Latches the store mode from the store-enable pin during reset, recalls the
// saved position once after reset, and starts nonvolatile writes either
// after an inactivity period (automatic) or on a debounced press-and-release
// of the pin (manual). Assumes tick_ms is a one-cycle pulse per millisecond.
module wiper_store_ctrl #(
    parameter int POS_W   = 4,
    parameter int IDLE_MS = 2000,
    parameter int DEB_MS  = 15,
    parameter int WR_MS   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en_n,
    input  logic             step_act,
    input  logic [POS_W-1:0] cur_pos,
    input  logic             tick_ms,
    output logic [POS_W-1:0] recall_pos,
    output logic             recall_load,
    output logic             nv_busy,
    output logic             step_inhibit
);
    import wsc_pkg::*;

    localparam logic [POS_W-1:0] MID_SCALE = POS_W'(1) << (POS_W - 1);

    store_mode_e      mode;
    logic             recall_pend;
    logic             pin_sync, pin_lvl, pin_rise;
    logic             idle_expire;
    logic             start_wr;
    logic [POS_W-1:0] nv_q;

    // Mode capture: follows the synchronised pin only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= pin_sync ? MODE_MANUAL : MODE_AUTO;
        end
    end

    // Recall strobe: one cycle right after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recall_pend <= 1'b1;
            recall_load <= 1'b0;
        end else begin
            recall_load <= recall_pend;
            recall_pend <= 1'b0;
        end
    end

    wsc_pin_filter #(.DEB_TICKS(DEB_MS)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .pin_raw  (store_en_n),
        .pin_sync (pin_sync),
        .lvl      (pin_lvl),
        .rise     (pin_rise)
    );

    wsc_idle_timer #(.IDLE_TICKS(IDLE_MS)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (mode == MODE_AUTO),
        .tick   (tick_ms),
        .act    (step_act),
        .hold   (nv_busy),
        .expire (idle_expire)
    );

    // Store request: mode-dependent trigger, skipped in auto mode if unchanged.
    always_comb begin
        if (mode == MODE_AUTO) begin
            start_wr = idle_expire && (cur_pos != nv_q);
        end else begin
            start_wr = pin_rise && !nv_busy;
        end
    end

    wsc_nv_cell #(.W(POS_W), .WR_TICKS(WR_MS), .INIT(MID_SCALE)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_ms),
        .start (start_wr),
        .din   (cur_pos),
        .busy  (nv_busy),
        .q     (nv_q)
    );

    assign recall_pos   = nv_q;
    assign step_inhibit = nv_busy ||
                          ((mode == MODE_MANUAL) && (!pin_sync || !pin_lvl));

    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_load |=> !recall_load); // R2
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode)); // R1

endmodule

// File: tb/tb_wiper_store_ctrl.sv
module tb_wiper_store_ctrl;
    localparam int IDLE = 2000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       store_en_n = 1'b0;
    logic       step_act = 1'b0;
    logic [3:0] cur_pos = 4'd0;
    logic       tick_ms = 1'b1;
    logic [3:0] recall_pos;
    logic       recall_load;
    logic       nv_busy;
    logic       step_inhibit;

    int n_vec = 0;
    int n_bad = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    wiper_store_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .store_en_n   (store_en_n),
        .step_act     (step_act),
        .cur_pos      (cur_pos),
        .tick_ms      (tick_ms),
        .recall_pos   (recall_pos),
        .recall_load  (recall_load),
        .nv_busy      (nv_busy),
        .step_inhibit (step_inhibit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Monitor: pops the expected recall value on each strobe (R2).
    always @(negedge clk) begin
        if (rst_n && recall_load) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected recall strobe", 1, 0);
            end else begin
                chk("R2 recalled position", int'(recall_pos), exp_q.pop_front());
            end
        end
    end

    // Driver: reset with a given pin level and queue the expected recall.
    task automatic do_reset(input logic pin, input int exp_recall);
        @(negedge clk);
        store_en_n = pin;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 no strobe in reset", int'(recall_load), 0);
        chk("R8 not busy in reset", int'(nv_busy), 0);
        exp_q.push_back(exp_recall);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 strobe consumed", exp_q.size(), 0);
    endtask

    task automatic pulse_act();
        step_act = 1'b1;
        @(negedge clk);
        step_act = 1'b0;
    endtask

    task automatic watch(input int n, output int bcnt, output int icnt);
        bcnt = 0;
        icnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (nv_busy) bcnt++;
            if (step_inhibit) icnt++;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && nv_busy; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int bc, ic, len;
        bit inh16, inh17;

        // Automatic mode, nothing stored yet: middle scale recalled.
        do_reset(1'b0, 8); // R3
        chk("R1 auto no inhibit", int'(step_inhibit), 0);

        // Idle expiry starts a store exactly IDLE cycles after activity.
        cur_pos = 4'd5;
        pulse_act();
        repeat (IDLE - 1) @(negedge clk);
        chk("R4 busy not yet", int'(nv_busy), 0);
        @(negedge clk);
        chk("R4 busy on expiry", int'(nv_busy), 1);
        chk("R8 inhibit while busy", int'(step_inhibit), 1);
        cur_pos = 4'd6;
        step_act = 1'b1;
        len = 0;
        while (nv_busy && len < 100) begin
            len++;
            @(negedge clk);
            step_act = 1'b0;
        end
        chk("R8 write window length", len, 20);
        watch(IDLE + 20, bc, ic);
        chk("R9 activity during write ignored", bc, 0);

        // Same value as saved: skipped. No activity: nothing.
        cur_pos = 4'd5;
        pulse_act();
        watch(IDLE + 20, bc, ic);
        chk("R5 unchanged value skipped", bc, 0);
        cur_pos = 4'd7;
        watch(IDLE + 20, bc, ic);
        chk("R5 no store without activity", bc, 0);

        // Restart of the idle count by new activity.
        cur_pos = 4'd9;
        pulse_act();
        repeat (IDLE / 2) @(negedge clk);
        pulse_act();
        repeat (IDLE - 1) @(negedge clk);
        chk("R4 restart delays store", int'(nv_busy), 0);
        @(negedge clk);
        chk("R4 store after restart", int'(nv_busy), 1);
        wait_idle();

        // Pin toggling in auto mode does nothing.
        store_en_n = 1'b1;
        watch(40, bc, ic);
        store_en_n = 1'b0;
        begin
            int bc2, ic2;
            watch(40, bc2, ic2);
            chk("R1 auto pin no store", bc + bc2, 0);
            chk("R1 auto pin no inhibit", ic + ic2, 0);
        end

        do_reset(1'b0, 9); // R2 saved value survives reset

        // Manual mode.
        do_reset(1'b1, 9);
        chk("R7 manual idle no inhibit", int'(step_inhibit), 0);
        cur_pos = 4'd3;
        pulse_act();
        watch(IDLE + 20, bc, ic);
        chk("R10 manual ignores activity", bc, 0);

        // Short glitch: inhibit follows, but no store.
        store_en_n = 1'b0;
        @(negedge clk);
        chk("R7 inhibit not yet", int'(step_inhibit), 0);
        @(negedge clk);
        chk("R7 inhibit on low pin", int'(step_inhibit), 1);
        repeat (8) @(negedge clk);
        store_en_n = 1'b1;
        watch(60, bc, ic);
        chk("R6 short low ignored", bc, 0);

        // Full press and release.
        store_en_n = 1'b0;
        repeat (40) @(negedge clk);
        store_en_n = 1'b1;
        len = 0;
        inh16 = 1'b0;
        inh17 = 1'b1;
        while (!nv_busy && len < 100) begin
            @(negedge clk);
            len++;
            if (len == 16) inh16 = step_inhibit;
            if (len == 17) inh17 = step_inhibit;
        end
        chk("R6 store after release", len, 18);
        chk("R7 inhibit until debounced high", int'(inh16), 1);
        chk("R7 inhibit released", int'(inh17), 0);
        wait_idle();

        do_reset(1'b1, 3); // R6 manual store committed

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule